// File: doc/BRIEF.md
# Tear-free 64-bit counter and configuration bank

This block holds eight 64-bit registers behind a 32-bit memory-mapped port. One is a configuration register. Seven are free-running event counters: three count request pulses (dequeued, outbound encrypt, inbound decrypt) and four accumulate byte amounts.

Each 64-bit register occupies two word addresses. The word at the lower address holds bits 63..32. The word four bytes above it holds bits 31..0.

Writing a 64-bit value takes two bus writes:
- The upper-bits word only loads a shared staging latch.
- The lower-bits word at the higher address commits staging and data together in one edge.

Reading a 64-bit value also takes two bus reads. Reading either half freezes the partner half in a per-register capture, so a counter that keeps running still returns a consistent 64-bit value over two reads.

Bit 31 of the configuration register is a software reset. When a committing write carries it set, every counter is cleared and a one-cycle pulse is sent out. The bit itself is never stored.

Top module: `wide_ctr_bank`

## Requirements
- R1: The register with index k sits at byte offset 8k. Offset 8k holds bits 63..32 and offset 8k+4 holds bits 31..0. The indices are assigned as follows:
  - 0 is configuration.
  - 1, 2 and 3 are the counters for `req_evt` bits 0, 1 and 2.
  - 4 to 7 are the counters for `byte_amt` slots 0 to 3. Slot j occupies bits 5j+4..5j.
- R2: A write to offset 8k only loads the staging latch. Register k keeps its value.
- R3: A write to offset 8k+4 loads register k with {staging, write data} at that edge, then clears staging. Staging also resets to zero, so a write to the lower-bits word alone leaves bits 63..32 at zero.
- R4: A read returns on `rd_data` with `rd_valid` high in the cycle after the request. The value is the register as it stood at the request edge.
- R5: A read of one half captures the other half of the same value. The next read of that other half returns the captured word, even if the counter has moved on. That read releases the capture.
- R6: A committing write to a register discards its pending capture. A read of the partner half then returns the live value.
- R7: A request counter adds 1 in each cycle its `req_evt` bit is high. A byte counter adds its 5-bit slot value, 0 to 16, each cycle.
- R8: Counters wrap from 2^64-1 to 0.
- R9: A committing write to a counter wins over an increment in the same cycle. The increment is lost.
- R10: A committing write to the configuration register stores every bit except bit 31, which always reads 0. If the write carries bit 31 set, all counters clear at that edge and `sw_reset_pulse` is high for exactly the next cycle. If bit 31 is clear, no pulse is produced.
- R11: Misaligned addresses (low two bits nonzero) and offsets at or beyond 64 are ignored on writes, including by the staging latch. Reads of them return 0.
- R12: After reset, all registers and staging are zero, and `rd_valid` and `sw_reset_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| req_evt | input | 3 | One-cycle request event pulses |
| byte_amt | input | 20 | Per-cycle byte amounts, 5 bits per slot |
| cfg_value | output | 64 | Configuration register contents |
| sw_reset_pulse | output | 1 | One-cycle software reset pulse |

## Verification
There are two same-cycle collisions that matter here.

The first is a counter increment landing in the same cycle as a read that captures the partner half. The bench holds a byte amount of 16 while it reads a counter loaded at 0x00000000_FFFFFFF0, so the carry crosses into the upper word between the two reads. It expects the pair 0 / 0xFFFFFFF0, not a torn value.

The second is a committing write arriving while `req_evt` is high. Here the bench expects the written value back, with no extra count.

// File: rtl/wcb_pkg.sv
`timescale 1ns/1ps
package wcb_pkg;
  localparam int WORD_W = 32;
  localparam int REG_W  = 64;
  // address bit 2 selects the half: 0 -> bits 63..32, 1 -> bits 31..0
  typedef enum logic {HALF_HI = 1'b0, HALF_LO = 1'b1} half_e;
endpackage

// File: rtl/wcb_stage.sv
`timescale 1ns/1ps
module wcb_stage
  import wcb_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  half_e                wr_half,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [NREG-1:0]      commit,
  output logic [REG_W-1:0]     commit_val
);
  logic [WORD_W-1:0] stage_q;

  // upper-bits word waits here; the lower-bits word commits and empties it
  always_ff @(posedge clk) begin
    if (!rst_n)                 stage_q <= '0;
    else if (wr_en) begin
      if (wr_half == HALF_HI)   stage_q <= wr_data;
      else                      stage_q <= '0;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_commit
    assign commit[k] = wr_en && (wr_half == HALF_LO) && (wr_idx == IDX_W'(k));
  end

  assign commit_val = {stage_q, wr_data};
endmodule

// File: rtl/wcb_counter.sv
`timescale 1ns/1ps
module wcb_counter
  import wcb_pkg::*;
#(
  parameter int INC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [REG_W-1:0]  load_val,
  input  logic [INC_W-1:0]  inc,
  output logic [REG_W-1:0]  q
);
  // clear > load > increment; the sum wraps at 64 bits
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (load)  q <= load_val;
    else            q <= q + REG_W'(inc);
  end
endmodule

// File: rtl/wcb_shadow.sv
`timescale 1ns/1ps
module wcb_shadow
  import wcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  half_e             rd_half,
  input  logic              drop,
  input  logic [REG_W-1:0]  live,
  output logic [WORD_W-1:0] out_word
);
  logic              pend_q;
  half_e             pend_half_q;
  logic [WORD_W-1:0] hold_q;
  logic              use_hold;
  logic [WORD_W-1:0] live_word;
  logic [WORD_W-1:0] other_word;

  assign use_hold   = pend_q && (pend_half_q == rd_half);
  assign live_word  = (rd_half == HALF_HI) ? live[63:32] : live[31:0];
  assign other_word = (rd_half == HALF_HI) ? live[31:0]  : live[63:32];
  assign out_word   = use_hold ? hold_q : live_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_half_q <= HALF_HI;
      hold_q      <= '0;
    end else if (drop) begin
      pend_q <= 1'b0;
    end else if (rd_hit) begin
      if (use_hold) begin
        pend_q <= 1'b0;
      end else begin
        pend_q      <= 1'b1;
        pend_half_q <= (rd_half == HALF_HI) ? HALF_LO : HALF_HI;
        hold_q      <= other_word;
      end
    end
  end
endmodule

// File: rtl/wide_ctr_bank.sv
`timescale 1ns/1ps
module wide_ctr_bank
  import wcb_pkg::*;
#(
  parameter int REQ_N  = 3,
  parameter int BYTE_N = 4,
  parameter int INC_W  = 5,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic                    rd_valid,
  output logic [WORD_W-1:0]       rd_data,
  input  logic [REQ_N-1:0]        req_evt,
  input  logic [BYTE_N*INC_W-1:0] byte_amt,
  output logic [REG_W-1:0]        cfg_value,
  output logic                    sw_reset_pulse
);
  localparam int NREG  = 1 + REQ_N + BYTE_N;
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0]  idx;
  half_e             half;
  logic              mapped, wr_en, rd_en, clr_all;
  logic [NREG-1:0]   commit;
  logic [REG_W-1:0]  commit_val;
  logic [REG_W-1:0]  live  [NREG];
  logic [WORD_W-1:0] words [NREG];
  logic [WORD_W-1:0] sel_word;
  logic [REG_W-1:0]  cfg_q;
  logic              pulse_q;

  assign idx     = bus_addr[ADDR_W-1:3];
  assign half    = half_e'(bus_addr[2]);
  assign mapped  = (bus_addr[1:0] == 2'b00) && (int'(idx) < NREG);
  assign wr_en   = bus_valid && bus_write && mapped;
  assign rd_en   = bus_valid && !bus_write;
  assign clr_all = commit[0] && commit_val[31];

  wcb_stage #(.NREG(NREG), .IDX_W(IDX_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_half(half), .wr_idx(idx),
    .wr_data(bus_wdata), .commit(commit), .commit_val(commit_val)
  );

  // configuration register: bit 31 is an action, never stored
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= clr_all;
      if (commit[0]) cfg_q <= {commit_val[63:32], 1'b0, commit_val[30:0]};
    end
  end
  assign live[0] = cfg_q;

  for (genvar i = 0; i < REQ_N; i++) begin : g_req
    wcb_counter #(.INC_W(1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .load(commit[1+i]),
      .load_val(commit_val), .inc(req_evt[i]), .q(live[1+i])
    );
  end

  for (genvar j = 0; j < BYTE_N; j++) begin : g_byte
    wcb_counter #(.INC_W(INC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .load(commit[1+REQ_N+j]),
      .load_val(commit_val), .inc(byte_amt[j*INC_W +: INC_W]),
      .q(live[1+REQ_N+j])
    );
  end

  for (genvar k = 0; k < NREG; k++) begin : g_shadow
    wcb_shadow u_shd (
      .clk(clk), .rst_n(rst_n),
      .rd_hit(rd_en && mapped && (idx == IDX_W'(k))),
      .rd_half(half), .drop(commit[k] || clr_all),
      .live(live[k]), .out_word(words[k])
    );
  end

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < NREG; k++)
      if (idx == IDX_W'(k)) sel_word = words[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= (rd_en && mapped) ? sel_word : '0;
    end
  end

  assign cfg_value      = cfg_q;
  assign sw_reset_pulse = pulse_q;
endmodule

// File: rtl/wide_ctr_bank_chk.sv
`timescale 1ns/1ps
module wide_ctr_bank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic [63:0]       cfg_value,
  input logic              sw_reset_pulse
);
  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == '0) |=> $stable(cfg_value));

  p_cfg_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(4)) |=>
      (cfg_value[30:0] == $past(bus_wdata[30:0])) && !cfg_value[31]);

  p_rd_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  p_rd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rd_valid);

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_pulse |=> !sw_reset_pulse);

  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_pulse |-> $past(bus_valid && bus_write &&
                             bus_addr == ADDR_W'(4) && bus_wdata[31]));

  p_misaligned_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr[1:0] != 2'b00) |=>
      (rd_valid && rd_data == '0));
endmodule

bind wide_ctr_bank wide_ctr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .cfg_value(cfg_value), .sw_reset_pulse(sw_reset_pulse)
);

// File: tb/sim_wide_ctr_bank.sv
`timescale 1ns/1ps
module sim_wide_ctr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [2:0]  req_evt = '0;
  logic [19:0] byte_amt = '0;
  logic [63:0] cfg_value;
  logic        sw_reset_pulse;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;
  logic [31:0] r;

  always #5 clk = ~clk;

  wide_ctr_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .req_evt(req_evt), .byte_amt(byte_amt),
    .cfg_value(cfg_value), .sw_reset_pulse(sw_reset_pulse)
  );

  // {write, addr, wdata, check, expected}
  localparam logic [73:0] VEC [16] = '{
    {1'b1, 8'h00, 32'h0000_1234, 1'b0, 32'h0},          // R2 stage only
    {1'b0, 8'h00, 32'h0,         1'b1, 32'h0},          // R2 cfg unchanged
    {1'b1, 8'h04, 32'h0000_0055, 1'b0, 32'h0},          // R3 commit
    {1'b0, 8'h04, 32'h0,         1'b1, 32'h0000_0055},  // R6 capture dropped
    {1'b0, 8'h00, 32'h0,         1'b1, 32'h0000_1234},  // R5 captured upper
    {1'b0, 8'h00, 32'h0,         1'b1, 32'h0000_1234},  // R3 upper committed
    {1'b0, 8'h04, 32'h0,         1'b1, 32'h0000_0055},  // R1 lower half
    {1'b1, 8'h0C, 32'hAAAA_0001, 1'b0, 32'h0},          // R3 lone lower write
    {1'b0, 8'h08, 32'h0,         1'b1, 32'h0},          // R3 upper zero
    {1'b0, 8'h0C, 32'h0,         1'b1, 32'hAAAA_0001},  // R1
    {1'b1, 8'h09, 32'h0000_DEAD, 1'b0, 32'h0},          // R11 misaligned write
    {1'b1, 8'h14, 32'h0000_0007, 1'b0, 32'h0},          // R11 commit
    {1'b0, 8'h10, 32'h0,         1'b1, 32'h0},          // R11 staging untouched
    {1'b0, 8'h14, 32'h0,         1'b1, 32'h0000_0007},  // R1
    {1'b0, 8'h40, 32'h0,         1'b1, 32'h0},          // R11 unmapped read
    {1'b0, 8'h0A, 32'h0,         1'b1, 32'h0}           // R11 misaligned read
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // call just after a negedge; returns at the next negedge with read data
  task automatic op(input logic we, input logic [7:0] a, input logic [31:0] d,
                    output logic [31:0] rv);
    bus_valid = 1'b1; bus_write = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    rv = rd_data;
    if (!we) chk("R4 rd_valid", 64'(rd_valid), 64'd1);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 rd_valid", 64'(rd_valid), 64'd0);
    chk("R12 pulse", 64'(sw_reset_pulse), 64'd0);
    chk("R12 cfg", cfg_value, 64'd0);

    for (int i = 0; i < 16; i++) begin
      op(VEC[i][73], VEC[i][72:65], VEC[i][64:33], r);
      if (VEC[i][32]) chk($sformatf("table step %0d", i), 64'(r), 64'(VEC[i][31:0]));
    end

    // R7 event accumulation: 5 pulses on bit 0, 3 cycles of 16 on slot 0, 9 on slot 2
    req_evt = 3'b001; byte_amt = {5'd0, 5'd9, 5'd0, 5'd16};
    repeat (3) @(negedge clk);
    byte_amt = '0;
    repeat (2) @(negedge clk);
    req_evt = '0;
    op(1'b0, 8'h0C, 32'h0, r); chk("R7 req count", 64'(r), 64'hAAAA_0006);
    op(1'b0, 8'h08, 32'h0, r); chk("R7 req upper", 64'(r), 64'h0);
    op(1'b0, 8'h24, 32'h0, r); chk("R7 byte slot0", 64'(r), 64'd48);
    op(1'b0, 8'h34, 32'h0, r); chk("R7 byte slot2", 64'(r), 64'd27);

    // R5 coherence across a carry while reading
    op(1'b1, 8'h20, 32'h0, r);
    op(1'b1, 8'h24, 32'hFFFF_FFF0, r);
    byte_amt = {15'd0, 5'd16};
    op(1'b0, 8'h20, 32'h0, r); chk("R5 upper at read", 64'(r), 64'h0);
    op(1'b0, 8'h24, 32'h0, r); chk("R5 captured lower", 64'(r), 64'hFFFF_FFF0);
    byte_amt = '0;
    op(1'b0, 8'h24, 32'h0, r); chk("R5 live lower", 64'(r), 64'h10);
    op(1'b0, 8'h20, 32'h0, r); chk("R5 carried upper", 64'(r), 64'h1);

    // R9 commit beats same-cycle increment
    req_evt = 3'b001;
    op(1'b1, 8'h08, 32'h0, r);
    op(1'b1, 8'h0C, 32'h0000_0100, r);
    req_evt = '0;
    op(1'b0, 8'h0C, 32'h0, r); chk("R9 load wins", 64'(r), 64'h100);

    // R8 wrap
    op(1'b1, 8'h18, 32'hFFFF_FFFF, r);
    op(1'b1, 8'h1C, 32'hFFFF_FFFF, r);
    req_evt = 3'b100;
    @(negedge clk);
    req_evt = '0;
    op(1'b0, 8'h1C, 32'h0, r); chk("R8 wrap lower", 64'(r), 64'h0);
    op(1'b0, 8'h18, 32'h0, r); chk("R8 wrap upper", 64'(r), 64'h0);

    // R10 config commit without and with the reset bit
    op(1'b1, 8'h00, 32'h0000_ABCD, r);
    op(1'b1, 8'h04, 32'h0000_0012, r);
    chk("R10 no pulse", 64'(sw_reset_pulse), 64'd0);
    op(1'b0, 8'h0C, 32'h0, r); chk("R10 counter kept", 64'(r), 64'h100);
    op(1'b1, 8'h00, 32'h0000_ABCD, r);
    op(1'b1, 8'h04, 32'h8000_0012, r);
    chk("R10 pulse high", 64'(sw_reset_pulse), 64'd1);
    chk("R10 cfg value", cfg_value, 64'h0000_ABCD_0000_0012);
    @(negedge clk);
    chk("R10 pulse single", 64'(sw_reset_pulse), 64'd0);
    op(1'b0, 8'h0C, 32'h0, r); chk("R10 req cleared", 64'(r), 64'h0);
    op(1'b0, 8'h34, 32'h0, r); chk("R10 byte cleared", 64'(r), 64'h0);
    op(1'b0, 8'h04, 32'h0, r); chk("R10 bit31 reads 0", 64'(r), 64'h12);
    op(1'b0, 8'h00, 32'h0, r); chk("R1 cfg upper", 64'(r), 64'hABCD);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule